// File: doc/BRIEF.md
# Three-Line External Interrupt Request Controller

This block takes three external interrupt request lines, each fixed at its own priority level (1, 6 or 7). It works out the highest level that is pending and presents it to an external host processor as a 3-bit active-low request code. Each line passes through a two-flop synchroniser. It is then detected by level or by falling edge, depending on a per-line select bit. The select bits apply only while the dedicated-pin mode input is high. Otherwise every line is level-sensitive.

The host answers with an interrupt-acknowledge strobe and the 3-bit level it is serving. The block responds only when the global vector-generation enable and the per-level vector enable are both set. It then clears the edge latch for that level and returns an 8-bit vector. The vector is the 5-bit base input followed by the 3-bit level, and it comes with a one-cycle transfer-acknowledge pulse. If vector generation is off, an edge latch is never cleared, and the request code stays asserted until the mode changes. A level-sensitive request drops as soon as its line goes high.

Top module: `ext_irq_ctrl`

## Requirements
- R1: With dedicated mode high and a select bit at 0, that line is pending while the input is low. The request code returns to 3'b111 once the line goes high and nothing else is pending.
- R2: With dedicated mode high and a select bit at 1, a high-to-low transition of the synchronised line latches a pending flag. The flag stays set after the line returns high.
- R3: With dedicated mode low, all lines are level-sensitive whatever the select bits say.
- R4: Priority is 7 over 6 over 1. The request code is the bitwise inverse of the winning level: 3'b000 for level 7, 3'b001 for level 6, 3'b110 for level 1, and 3'b111 when idle.
- R5: A level-mode input change appears on the request code exactly three rising clock edges after it is applied, and not after two.
- R6: An acknowledge strobe rising with vector generation on and the addressed level's vector enable set (bit 0 = level 1, bit 1 = level 6, bit 2 = level 7) gives a transfer-acknowledge on the next edge for exactly one cycle. The vector is {base, level}, and the edge latch of that level is cleared.
- R7: With vector generation off, an acknowledge gives no transfer-acknowledge and leaves an edge latch and the request code unchanged.
- R8: A level-6 acknowledge still returns its vector and transfer-acknowledge when the level-6 line is released in the same cycle the acknowledge starts.
- R9: An acknowledge for a level whose vector enable is clear, or for a level other than 1, 6 or 7, gives no transfer-acknowledge, a zero vector, and no change to the pending state.
- R10: After reset the request code is 3'b111, and the transfer-acknowledge and the vector are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_i | input | 3 | Active-low request lines: bit 0 level 1, bit 1 level 6, bit 2 level 7 |
| dedicated_i | input | 1 | Dedicated-pin mode; enables the trigger select bits |
| edge_sel_i | input | 3 | Per-line trigger select: 1 falling edge, 0 level |
| vgen_en_i | input | 1 | Global vector-generation enable |
| vec_en_i | input | 3 | Per-level vector enable, same bit order as irq_n_i |
| vec_base_i | input | 5 | Upper five bits of the returned vector |
| iack_i | input | 1 | Host interrupt-acknowledge strobe |
| iack_lvl_i | input | 3 | Level being acknowledged |
| ipl_n_o | output | 3 | Active-low encoded highest pending level |
| vec_o | output | 8 | Returned vector, zero when not acknowledging |
| dtack_o | output | 1 | One-cycle transfer-acknowledge pulse |

## Verification
A stuck or lost edge latch shows up on the request code within four edges of the line's falling edge. It also shows up one edge after an acknowledge should have cleared the latch: the code either keeps showing a level that was served or never shows one that fell. A wrong response decision shows up on the very next edge after the acknowledge strobe rises, as a missing or unexpected transfer-acknowledge or as a wrong vector. A synchroniser with the wrong depth moves the request code by one edge from the three-edge point at which the level tests sample.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int NLINES = 3;
    localparam int LVL_W  = 3;
    localparam int VEC_W  = 8;
    localparam int BASE_W = VEC_W - LVL_W;

    // Priority level wired to each line index; a higher index wins.
    localparam logic [LVL_W-1:0] LINE_LEVEL [NLINES] = '{3'd1, 3'd6, 3'd7};

    typedef struct packed {
        logic             dtack;
        logic [VEC_W-1:0] vec;
    } ack_resp_t;

    // Highest pending level, or 0 when nothing is pending.
    function automatic logic [LVL_W-1:0] top_level(input logic [NLINES-1:0] pend);
        logic [LVL_W-1:0] lvl;
        lvl = '0;
        for (int k = 0; k < NLINES; k++) begin
            if (pend[k]) lvl = LINE_LEVEL[k];
        end
        return lvl;
    endfunction

    // One-hot line select for an acknowledged level.
    function automatic logic [NLINES-1:0] level_hit(input logic [LVL_W-1:0] lvl);
        logic [NLINES-1:0] hit;
        for (int k = 0; k < NLINES; k++) begin
            hit[k] = (lvl == LINE_LEVEL[k]);
        end
        return hit;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int N      = ext_irq_pkg::NLINES,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] irq_n,
    output logic [N-1:0] lvl_act,
    output logic [N-1:0] fall
);

    for (genvar k = 0; k < N; k++) begin : g_line
        // chain[STAGES-1] is the synchronised value, chain[STAGES] its previous value
        logic [STAGES:0] chain;

        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-1:0], irq_n[k]};
        end

        assign lvl_act[k] = ~chain[STAGES-1];
        assign fall[k]    = chain[STAGES] & ~chain[STAGES-1];
    end

endmodule

// File: rtl/ext_irq_pend.sv
module ext_irq_pend #(
    parameter int N = ext_irq_pkg::NLINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] lvl_act,
    input  logic [N-1:0] fall,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    logic [N-1:0] flag;

    for (genvar k = 0; k < N; k++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst || !edge_mode[k]) flag[k] <= 1'b0;
            else if (fall[k])         flag[k] <= 1'b1;   // new edge beats a clear
            else if (clr[k])          flag[k] <= 1'b0;
        end

        assign pend[k] = edge_mode[k] ? flag[k] : lvl_act[k];

        // R2: a latched edge survives until an acknowledge clears it
        a_r2_edge_hold: assert property (@(posedge clk) disable iff (rst)
            (edge_mode[k] && flag[k] && !clr[k]) |=> flag[k]);

        // R6: an acknowledge with no new edge empties the latch
        a_r6_ack_clear: assert property (@(posedge clk) disable iff (rst)
            (clr[k] && !fall[k]) |=> !flag[k]);
    end

endmodule

// File: rtl/ext_irq_prio.sv
module ext_irq_prio
    import ext_irq_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     pend,
    output logic [LVL_W-1:0] ipl_n
);

    always_ff @(posedge clk) begin
        if (rst) ipl_n <= '1;
        else     ipl_n <= ~top_level(pend);
    end

    // R4: nothing pending means the idle code
    a_r4_idle_code: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |=> (ipl_n == '1));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irq_n_i,
    input  logic              dedicated_i,
    input  logic [NLINES-1:0] edge_sel_i,
    input  logic              vgen_en_i,
    input  logic [NLINES-1:0] vec_en_i,
    input  logic [BASE_W-1:0] vec_base_i,
    input  logic              iack_i,
    input  logic [LVL_W-1:0]  iack_lvl_i,
    output logic [LVL_W-1:0]  ipl_n_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              dtack_o
);

    logic [NLINES-1:0] lvl_act, fall, pend, edge_mode, resp_sel, clr;
    logic              iack_q, ack_rise, respond;
    ack_resp_t         resp_q;

    assign edge_mode = {NLINES{dedicated_i}} & edge_sel_i;

    ext_irq_sync #(.N(NLINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .irq_n(irq_n_i), .lvl_act(lvl_act), .fall(fall)
    );

    ext_irq_pend #(.N(NLINES)) pend_i (
        .clk(clk), .rst(rst), .edge_mode(edge_mode), .lvl_act(lvl_act),
        .fall(fall), .clr(clr), .pend(pend)
    );

    ext_irq_prio #(.N(NLINES)) prio_i (
        .clk(clk), .rst(rst), .pend(pend), .ipl_n(ipl_n_o)
    );

    // Acknowledge handling: one response per strobe rising edge
    always_ff @(posedge clk) begin
        if (rst) iack_q <= 1'b0;
        else     iack_q <= iack_i;
    end

    assign ack_rise = iack_i & ~iack_q;
    assign resp_sel = level_hit(iack_lvl_i) & vec_en_i & {NLINES{vgen_en_i}};
    assign respond  = ack_rise & (|resp_sel);
    assign clr      = {NLINES{ack_rise}} & resp_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.dtack <= respond;
            resp_q.vec   <= respond ? {vec_base_i, iack_lvl_i} : '0;
        end
    end

    assign dtack_o = resp_q.dtack;
    assign vec_o   = resp_q.vec;

    // R6: transfer-acknowledge lasts one cycle
    a_r6_dtack_single: assert property (@(posedge clk) disable iff (rst)
        dtack_o |=> !dtack_o);

    // R7: no vector generation, no transfer-acknowledge
    a_r7_no_gen_no_dtack: assert property (@(posedge clk) disable iff (rst)
        (ack_rise && !vgen_en_i) |=> !dtack_o);

    // R9: a vector only ever appears with its strobe
    a_r9_vec_with_dtack: assert property (@(posedge clk) disable iff (rst)
        (vec_o != '0) |-> dtack_o);

endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] irq_n_i, edge_sel_i, vec_en_i, iack_lvl_i;
    logic       dedicated_i, vgen_en_i, iack_i;
    logic [4:0] vec_base_i;
    logic [2:0] ipl_n_o;
    logic [7:0] vec_o;
    logic       dtack_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ext_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .irq_n_i(irq_n_i), .dedicated_i(dedicated_i),
        .edge_sel_i(edge_sel_i), .vgen_en_i(vgen_en_i), .vec_en_i(vec_en_i),
        .vec_base_i(vec_base_i), .iack_i(iack_i), .iack_lvl_i(iack_lvl_i),
        .ipl_n_o(ipl_n_o), .vec_o(vec_o), .dtack_o(dtack_o)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Acknowledge; returns the response seen one edge after the strobe rises
    task automatic ack(input logic [2:0] lvl, output logic dt, output logic [7:0] v);
        iack_i = 1'b1; iack_lvl_i = lvl;
        step(1);
        dt = dtack_o; v = vec_o;
        iack_i = 1'b0;
        step(1);
        chk("R6 dtack single cycle", {7'd0, dtack_o}, 8'd0);
    endtask

    task automatic t_reset();
        chk("R10 ipl idle", {5'd0, ipl_n_o}, 8'h07);
        chk("R10 dtack low", {7'd0, dtack_o}, 8'd0);
        chk("R10 vec zero", vec_o, 8'd0);
    endtask

    task automatic t_level();
        dedicated_i = 1; edge_sel_i = 3'b000;
        irq_n_i = 3'b110;
        step(2);
        chk("R5 not after two edges", {5'd0, ipl_n_o}, 8'h07);
        step(1);
        chk("R5/R1 level1 after three edges", {5'd0, ipl_n_o}, 8'h06);
        irq_n_i = 3'b111;
        step(3);
        chk("R1 released", {5'd0, ipl_n_o}, 8'h07);
    endtask

    task automatic t_edge_nogen();
        logic dt; logic [7:0] v;
        dedicated_i = 1; edge_sel_i = 3'b100; vgen_en_i = 0; vec_en_i = 3'b111;
        irq_n_i = 3'b011;
        step(3);
        irq_n_i = 3'b111;
        step(5);
        chk("R2 edge latched after release", {5'd0, ipl_n_o}, 8'h00);
        ack(3'd7, dt, v);
        chk("R7 no dtack", {7'd0, dt}, 8'd0);
        step(3);
        chk("R7 latch kept", {5'd0, ipl_n_o}, 8'h00);
        vgen_en_i = 1; vec_base_i = 5'h0A;
        ack(3'd7, dt, v);
        chk("R6 dtack", {7'd0, dt}, 8'd1);
        chk("R6 vector", v, {5'h0A, 3'd7});
        step(2);
        chk("R6 latch cleared", {5'd0, ipl_n_o}, 8'h07);
    endtask

    task automatic t_priority();
        dedicated_i = 1; edge_sel_i = 3'b000;
        irq_n_i = 3'b100; step(4);
        chk("R4 six over one", {5'd0, ipl_n_o}, 8'h01);
        irq_n_i = 3'b000; step(4);
        chk("R4 seven wins", {5'd0, ipl_n_o}, 8'h00);
        irq_n_i = 3'b110; step(4);
        chk("R4 only one", {5'd0, ipl_n_o}, 8'h06);
        irq_n_i = 3'b111; step(4);
        chk("R4 idle", {5'd0, ipl_n_o}, 8'h07);
    endtask

    task automatic t_nodedicated();
        dedicated_i = 0; edge_sel_i = 3'b111;
        irq_n_i = 3'b101; step(4);
        chk("R3 level6 seen", {5'd0, ipl_n_o}, 8'h01);
        irq_n_i = 3'b111; step(4);
        chk("R3 select ignored, drops", {5'd0, ipl_n_o}, 8'h07);
    endtask

    task automatic t_ack6_release();
        logic dt; logic [7:0] v;
        dedicated_i = 1; edge_sel_i = 3'b000; vgen_en_i = 1; vec_en_i = 3'b111;
        vec_base_i = 5'h13;
        irq_n_i = 3'b101; step(4);
        irq_n_i = 3'b111;
        ack(3'd6, dt, v);
        chk("R8 dtack after release", {7'd0, dt}, 8'd1);
        chk("R8 vector", v, {5'h13, 3'd6});
        step(3);
    endtask

    task automatic t_no_resp();
        logic dt; logic [7:0] v;
        dedicated_i = 1; edge_sel_i = 3'b001; vgen_en_i = 1; vec_en_i = 3'b101;
        vec_base_i = 5'h1F;
        irq_n_i = 3'b110; step(3);
        irq_n_i = 3'b111; step(5);
        chk("R2 level1 edge latched", {5'd0, ipl_n_o}, 8'h06);
        ack(3'd6, dt, v);
        chk("R9 no dtack disabled level", {7'd0, dt}, 8'd0);
        chk("R9 zero vector", v, 8'd0);
        step(2);
        chk("R9 state kept", {5'd0, ipl_n_o}, 8'h06);
        ack(3'd3, dt, v);
        chk("R9 no dtack bad level", {7'd0, dt}, 8'd0);
        step(2);
        chk("R9 state kept bad level", {5'd0, ipl_n_o}, 8'h06);
        ack(3'd1, dt, v);
        chk("R6 level1 dtack", {7'd0, dt}, 8'd1);
        chk("R6 level1 vector", v, {5'h1F, 3'd1});
        step(2);
        chk("R6 level1 cleared", {5'd0, ipl_n_o}, 8'h07);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; irq_n_i = 3'b111; dedicated_i = 0; edge_sel_i = 0;
        vgen_en_i = 0; vec_en_i = 0; vec_base_i = 0; iack_i = 0; iack_lvl_i = 0;
        step(3);
        rst = 0;
        step(1);
        t_reset();
        t_level();
        t_edge_nogen();
        t_priority();
        t_nodedicated();
        t_ack6_release();
        t_no_resp();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule